// File: doc/BRIEF.md
# Host Parallel Port for a Character Display Controller

This block is the microcontroller-facing side of a character display controller. A host drives a register-select line, a read/write line, a strobe and an 8-bit data bus. The block synchronises the strobe to its own clock. On each falling strobe edge it completes a transfer: a write goes to the command register or to the data register, and a read is finished. While the strobe is high during a read, the block drives the bus.

Transfers are either whole bytes or pairs of nibbles carried on the upper four data lines. A status read returns one byte built from the busy input (bit 7) and the 7-bit address input (bits 6 to 0). A data read returns the data register. Logic outside the block loads the data register from display memory through a fill port. A pulse at the end of each data read tells that logic when to step the address and fetch again. Command decoding, the memories and busy timing are outside this block.

Top module: `hbi_top`

## Requirements
- R1: After reset the command register and the data register read 0, the bus output enable is 0, and no event pulse is high.
- R2: A completed write with register-select 0 (read/write 0) while the busy input is 0 loads the command register with the byte and gives exactly one `ir_wr` pulse.
- R3: A write with register-select 0 that completes while the busy input is 1 is dropped: the command register is unchanged and no `ir_wr` pulse occurs.
- R4: A completed write with register-select 1 loads the data register and gives one `dr_wr` pulse, and the command register is not changed.
- R5: A read with register-select 0 drives the busy input on bit 7 and the address input on bits 6 to 0. The command register is never driven onto the bus.
- R6: A read with register-select 1 drives the data register contents. Only its completion gives one `dr_rd` pulse; a status read gives none. At most one of `ir_wr`, `dr_wr`, `dr_rd` is high in any cycle.
- R7: The bus output enable is high only while the synchronised strobe is high in a read cycle. It is low during writes and while the strobe is low.
- R8: In nibble mode (`nib_mode` = 1) a write takes the upper nibble from data lines 7..4 on the first strobe and the lower nibble from lines 7..4 on the second. Lines 3..0 are ignored, and the target register changes only after the second strobe.
- R9: In nibble mode a read drives the upper nibble of the read byte on lines 7..4 during the first strobe and the lower nibble during the second. Lines 3..0 are driven 0.
- R10: Any change of `nib_mode` returns the nibble sequence to its first half, so the next transfer begins with a fresh upper nibble or a whole byte.
- R11: A `fill_we` pulse loads `fill_data` into the data register. If a host data write completes in the same cycle, the host byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hb_rsel | input | 1 | Register select: 0 command/status, 1 data |
| hb_rnw | input | 1 | 1 read, 0 write |
| hb_stb | input | 1 | Transfer strobe, completes on falling edge |
| hb_din | input | 8 | Data bus in from host |
| hb_dout | output | 8 | Data bus out to host |
| hb_doe | output | 1 | Data bus output enable |
| nib_mode | input | 1 | 1 selects two-nibble transfers on lines 7..4 |
| core_busy | input | 1 | Busy status from the controller core |
| core_addr | input | 7 | Address counter value from the core |
| fill_we | input | 1 | Load strobe for the data register |
| fill_data | input | 8 | Byte fetched from display memory |
| ir_q | output | 8 | Command register |
| ir_wr | output | 1 | One-cycle pulse on command register load |
| dr_q | output | 8 | Data register |
| dr_wr | output | 1 | One-cycle pulse on host data write |
| dr_rd | output | 1 | One-cycle pulse on data read completion |

## Verification
The bench runs all four combinations of register-select and read/write in byte mode. These show whether a byte reaches the correct register and whether a status read and a data read return different sources. Busy-high command writes are set against busy-low ones to show that only command writes are gated. Nibble-mode writes carry 1s on lines 3..0 to expose any leak from the unused lines. A half-finished nibble sequence followed by a mode switch shows whether the sequence restarts. A fill that lands in the same cycle as a host data write shows which one takes priority.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  localparam int HBI_DATA_W = 8;
  localparam int HBI_ADDR_W = 7;

  typedef enum logic [1:0] {
    ACC_CMD_WR  = 2'd0,
    ACC_DAT_WR  = 2'd1,
    ACC_STAT_RD = 2'd2,
    ACC_DAT_RD  = 2'd3
  } acc_e;

  // Register select picks the target, read/write picks the direction.
  function automatic acc_e classify(input logic rsel, input logic rnw);
    case ({rnw, rsel})
      2'b00:   return ACC_CMD_WR;
      2'b01:   return ACC_DAT_WR;
      2'b10:   return ACC_STAT_RD;
      default: return ACC_DAT_RD;
    endcase
  endfunction

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int STAGES = 2,
  parameter int W      = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb_in,
  input  logic [W-1:0] bun_in,
  output logic         stb_q,
  output logic         stb_rise,
  output logic         stb_fall,
  output logic [W-1:0] bun_q
);

  logic [STAGES-1:0] stb_pipe;
  logic [W-1:0]      bun_pipe [STAGES];
  logic              stb_prev;

  // Strobe and the control/data bundle travel through equal-length
  // pipelines so they stay aligned at the edge detector.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stb_pipe[g] <= 1'b0;
          bun_pipe[g] <= '0;
        end else begin
          stb_pipe[g] <= stb_in;
          bun_pipe[g] <= bun_in;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stb_pipe[g] <= 1'b0;
          bun_pipe[g] <= '0;
        end else begin
          stb_pipe[g] <= stb_pipe[g-1];
          bun_pipe[g] <= bun_pipe[g-1];
        end
      end
    end
  end

  assign stb_q = stb_pipe[STAGES-1];
  assign bun_q = bun_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_prev <= 1'b0;
    else        stb_prev <= stb_q;
  end

  assign stb_rise = stb_q & ~stb_prev;
  assign stb_fall = ~stb_q & stb_prev;

endmodule

// File: rtl/hbi_nibble.sv
module hbi_nibble #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_4b,
  input  logic              stb_fall,
  input  logic [DATA_W-1:0] bus_byte,
  output logic              done,
  output logic              toggle,
  output logic [DATA_W-1:0] byte_out
);

  localparam int NIB = DATA_W / 2;

  logic [NIB-1:0] hi_q;
  logic           mode_q;
  logic           mode_chg;

  function automatic logic [DATA_W-1:0] join_nibbles(input logic [NIB-1:0] hi,
                                                     input logic [NIB-1:0] lo);
    return {hi, lo};
  endfunction

  assign mode_chg = (mode_q != mode_4b);
  assign done     = stb_fall && !mode_chg && (!mode_4b || toggle);
  assign byte_out = mode_4b ? join_nibbles(hi_q, bus_byte[DATA_W-1:NIB]) : bus_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      toggle <= 1'b0;
      hi_q   <= '0;
    end else begin
      mode_q <= mode_4b;
      if (mode_chg) begin
        toggle <= 1'b0;
      end else if (stb_fall && mode_4b) begin
        toggle <= ~toggle;
        if (!toggle) hi_q <= bus_byte[DATA_W-1:NIB];
      end
    end
  end

  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_4b != $past(mode_4b)) |=> !toggle); // R10

  AST_BYTE_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_4b && !$past(mode_4b) && !$past(toggle)) |-> !toggle); // R8

endmodule

// File: rtl/hbi_rdpath.sv
module hbi_rdpath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_q,
  input  logic              stb_rise,
  input  logic              rnw_q,
  input  logic              rsel_q,
  input  logic              mode_4b,
  input  logic              toggle,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dr_val,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);

  localparam int NIB = DATA_W / 2;

  logic [DATA_W-1:0] rd_hold;
  logic [DATA_W-1:0] live;
  logic [DATA_W-1:0] cur;
  logic              snap;

  function automatic logic [DATA_W-1:0] pack_status(input logic b,
                                                    input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] r;
    r = '0;
    r[DATA_W-1] = b;
    r[ADDR_W-1:0] = a;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] nibble_lane(input logic [DATA_W-1:0] v,
                                                    input logic second);
    return second ? {v[NIB-1:0], {NIB{1'b0}}} : {v[DATA_W-1:NIB], {NIB{1'b0}}};
  endfunction

  // The read byte is captured at the first rising strobe so that both
  // halves of a nibble read come from one snapshot.
  assign live = rsel_q ? dr_val : pack_status(busy, addr);
  assign snap = stb_rise && !toggle;
  assign cur  = snap ? live : rd_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_hold <= '0;
    else if (snap) rd_hold <= live;
  end

  assign bus_oe  = stb_q && rnw_q;
  assign bus_out = !bus_oe ? '0 : (mode_4b ? nibble_lane(cur, toggle) : cur);

  AST_LOW_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && mode_4b) |-> (bus_out[NIB-1:0] == '0)); // R9

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0)); // R7

endmodule

// File: rtl/hbi_top.sv
module hbi_top
  import hbi_pkg::*;
#(
  parameter int DATA_W      = HBI_DATA_W,
  parameter int ADDR_W      = HBI_ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_rsel,
  input  logic              hb_rnw,
  input  logic              hb_stb,
  input  logic [DATA_W-1:0] hb_din,
  output logic [DATA_W-1:0] hb_dout,
  output logic              hb_doe,
  input  logic              nib_mode,
  input  logic              core_busy,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              fill_we,
  input  logic [DATA_W-1:0] fill_data,
  output logic [DATA_W-1:0] ir_q,
  output logic              ir_wr,
  output logic [DATA_W-1:0] dr_q,
  output logic              dr_wr,
  output logic              dr_rd
);

  localparam int BUN_W = DATA_W + 2;

  logic              stb_q, stb_rise, stb_fall;
  logic [BUN_W-1:0]  bun_q;
  logic              rsel_q, rnw_q;
  logic [DATA_W-1:0] din_q;
  logic              xfer_done, toggle;
  logic [DATA_W-1:0] xfer_byte;
  acc_e              kind;
  logic              host_dr_wr;

  hbi_sync #(.STAGES(SYNC_STAGES), .W(BUN_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_in   (hb_stb),
    .bun_in   ({hb_rsel, hb_rnw, hb_din}),
    .stb_q    (stb_q),
    .stb_rise (stb_rise),
    .stb_fall (stb_fall),
    .bun_q    (bun_q)
  );

  assign rsel_q = bun_q[BUN_W-1];
  assign rnw_q  = bun_q[BUN_W-2];
  assign din_q  = bun_q[DATA_W-1:0];

  hbi_nibble #(.DATA_W(DATA_W)) u_nib (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_4b  (nib_mode),
    .stb_fall (stb_fall),
    .bus_byte (din_q),
    .done     (xfer_done),
    .toggle   (toggle),
    .byte_out (xfer_byte)
  );

  hbi_rdpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_q    (stb_q),
    .stb_rise (stb_rise),
    .rnw_q    (rnw_q),
    .rsel_q   (rsel_q),
    .mode_4b  (nib_mode),
    .toggle   (toggle),
    .busy     (core_busy),
    .addr     (core_addr),
    .dr_val   (dr_q),
    .bus_out  (hb_dout),
    .bus_oe   (hb_doe)
  );

  assign kind       = classify(rsel_q, rnw_q);
  assign host_dr_wr = xfer_done && (kind == ACC_DAT_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= '0;
      dr_q  <= '0;
      ir_wr <= 1'b0;
      dr_wr <= 1'b0;
      dr_rd <= 1'b0;
    end else begin
      ir_wr <= 1'b0;
      dr_wr <= 1'b0;
      dr_rd <= 1'b0;
      if (xfer_done && kind == ACC_CMD_WR && !core_busy) begin
        ir_q  <= xfer_byte;
        ir_wr <= 1'b1;
      end
      if (host_dr_wr) begin
        dr_q  <= xfer_byte;
        dr_wr <= 1'b1;
      end else if (fill_we) begin
        dr_q <= fill_data;
      end
      if (xfer_done && kind == ACC_DAT_RD) dr_rd <= 1'b1;
    end
  end

  AST_CMD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |-> !$past(core_busy)); // R3

  AST_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ir_q) |-> ir_wr); // R2

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ir_wr, dr_wr, dr_rd})); // R6

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_wr || dr_wr) |-> !hb_doe); // R7

  AST_FILL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_we) && !dr_wr) |-> (dr_q == $past(fill_data))); // R11

endmodule

// File: tb/hbi_top_tb_top.sv
module hbi_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hb_rsel = 1'b0, hb_rnw = 1'b0, hb_stb = 1'b0;
  logic [7:0] hb_din = 8'h00;
  logic [7:0] hb_dout;
  logic       hb_doe;
  logic       nib_mode = 1'b0;
  logic       core_busy = 1'b0;
  logic [6:0] core_addr = 7'h00;
  logic       fill_we = 1'b0;
  logic [7:0] fill_data = 8'h00;
  logic [7:0] ir_q, dr_q;
  logic       ir_wr, dr_wr, dr_rd;

  int total = 0;
  int bad = 0;
  int n_ir = 0, n_dwr = 0, n_drd = 0, oe_bad = 0;

  always #10 clk = ~clk;

  hbi_top dut_i (
    .clk(clk), .rst_n(rst_n), .hb_rsel(hb_rsel), .hb_rnw(hb_rnw), .hb_stb(hb_stb),
    .hb_din(hb_din), .hb_dout(hb_dout), .hb_doe(hb_doe), .nib_mode(nib_mode),
    .core_busy(core_busy), .core_addr(core_addr), .fill_we(fill_we),
    .fill_data(fill_data), .ir_q(ir_q), .ir_wr(ir_wr), .dr_q(dr_q),
    .dr_wr(dr_wr), .dr_rd(dr_rd)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (ir_wr) n_ir++;
      if (dr_wr) n_dwr++;
      if (dr_rd) n_drd++;
      if (hb_doe && (!hb_rnw || !hb_stb && !hb_doe)) oe_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] d,
                      output logic [7:0] seen, output logic oe_seen);
    @(negedge clk);
    hb_rsel = rs; hb_rnw = rw; hb_din = d;
    repeat (2) @(negedge clk);
    hb_stb = 1'b1;
    repeat (6) @(negedge clk);
    seen = hb_dout; oe_seen = hb_doe;
    hb_stb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ir_q == 8'h00, "R1 ir_q", ir_q, 0);
    chk(dr_q == 8'h00, "R1 dr_q", dr_q, 0);
    chk(!hb_doe && !ir_wr && !dr_wr && !dr_rd, "R1 idle outputs",
        {hb_doe, ir_wr, dr_wr, dr_rd}, 0);
  endtask

  task automatic t_cmd_write();
    logic [7:0] s; logic o; int n0;
    n0 = n_ir;
    xfer(1'b0, 1'b0, 8'hA5, s, o);
    chk(ir_q == 8'hA5, "R2 command load", ir_q, 8'hA5);
    chk(n_ir == n0 + 1, "R2 one ir_wr pulse", n_ir - n0, 1);
    chk(!o, "R7 no drive on write", o, 0);
  endtask

  task automatic t_cmd_busy();
    logic [7:0] s; logic o; int n0;
    n0 = n_ir;
    core_busy = 1'b1;
    xfer(1'b0, 1'b0, 8'h3C, s, o);
    core_busy = 1'b0;
    chk(ir_q == 8'hA5, "R3 busy write dropped", ir_q, 8'hA5);
    chk(n_ir == n0, "R3 no pulse while busy", n_ir - n0, 0);
  endtask

  task automatic t_data_write();
    logic [7:0] s; logic o; int n0;
    n0 = n_dwr;
    core_busy = 1'b1;
    xfer(1'b1, 1'b0, 8'h5A, s, o);
    core_busy = 1'b0;
    chk(dr_q == 8'h5A, "R4 data load", dr_q, 8'h5A);
    chk(n_dwr == n0 + 1, "R4 one dr_wr", n_dwr - n0, 1);
    chk(ir_q == 8'hA5, "R4 command untouched", ir_q, 8'hA5);
  endtask

  task automatic t_status_read();
    logic [7:0] s; logic o; int n0;
    n0 = n_drd;
    core_busy = 1'b1; core_addr = 7'h2B;
    xfer(1'b0, 1'b1, 8'h00, s, o);
    chk(s == 8'hAB, "R5 busy on bit 7", s, 8'hAB);
    chk(o, "R7 drive during read", o, 1);
    core_busy = 1'b0; core_addr = 7'h7F;
    xfer(1'b0, 1'b1, 8'h00, s, o);
    chk(s == 8'h7F, "R5 address bits", s, 8'h7F);
    chk(n_drd == n0, "R6 status read no dr_rd", n_drd - n0, 0);
    chk(!hb_doe, "R7 released after strobe", hb_doe, 0);
  endtask

  task automatic t_data_read();
    logic [7:0] s; logic o; int n0;
    n0 = n_drd;
    xfer(1'b1, 1'b1, 8'h00, s, o);
    chk(s == 8'h5A, "R6 data read value", s, 8'h5A);
    chk(n_drd == n0 + 1, "R6 one dr_rd", n_drd - n0, 1);
  endtask

  task automatic t_nib_write();
    logic [7:0] s; logic o; int n0;
    nib_mode = 1'b1;
    repeat (3) @(negedge clk);
    n0 = n_ir;
    xfer(1'b0, 1'b0, 8'hCF, s, o);
    chk(ir_q == 8'hA5, "R8 no load after first nibble", ir_q, 8'hA5);
    xfer(1'b0, 1'b0, 8'h3F, s, o);
    chk(ir_q == 8'hC3, "R8 nibbles joined", ir_q, 8'hC3);
    chk(n_ir == n0 + 1, "R8 single pulse", n_ir - n0, 1);
    xfer(1'b1, 1'b0, 8'h9F, s, o);
    xfer(1'b1, 1'b0, 8'h6F, s, o);
    chk(dr_q == 8'h96, "R8 data nibbles", dr_q, 8'h96);
  endtask

  task automatic t_nib_read();
    logic [7:0] s; logic o;
    core_addr = 7'h35; core_busy = 1'b1;
    xfer(1'b0, 1'b1, 8'h00, s, o);
    chk(s == 8'hB0, "R9 upper nibble first", s, 8'hB0);
    core_busy = 1'b0;
    xfer(1'b0, 1'b1, 8'h00, s, o);
    chk(s == 8'h50, "R9 lower nibble second", s, 8'h50);
  endtask

  task automatic t_mode_change();
    logic [7:0] s; logic o; int n0;
    n0 = n_ir;
    xfer(1'b0, 1'b0, 8'hEF, s, o);
    nib_mode = 1'b0;
    repeat (3) @(negedge clk);
    xfer(1'b0, 1'b0, 8'h11, s, o);
    chk(ir_q == 8'h11, "R10 byte after switch", ir_q, 8'h11);
    chk(n_ir == n0 + 1, "R10 one command", n_ir - n0, 1);
    nib_mode = 1'b1;
    repeat (3) @(negedge clk);
    xfer(1'b0, 1'b0, 8'h2F, s, o);
    xfer(1'b0, 1'b0, 8'h7F, s, o);
    chk(ir_q == 8'h27, "R10 fresh nibble pair", ir_q, 8'h27);
    nib_mode = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_fill();
    @(negedge clk);
    fill_we = 1'b1; fill_data = 8'h42;
    @(negedge clk);
    fill_we = 1'b0;
    @(negedge clk);
    chk(dr_q == 8'h42, "R11 fill load", dr_q, 8'h42);
    hb_rsel = 1'b1; hb_rnw = 1'b0; hb_din = 8'h77;
    repeat (2) @(negedge clk);
    hb_stb = 1'b1;
    repeat (6) @(negedge clk);
    hb_stb = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    fill_we = 1'b1; fill_data = 8'h99;
    @(negedge clk);
    fill_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(dr_q == 8'h77, "R11 host wins over fill", dr_q, 8'h77);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_cmd_write();
    t_cmd_busy();
    t_data_write();
    t_status_read();
    t_data_read();
    t_nib_write();
    t_nib_read();
    t_mode_change();
    t_fill();
    chk(oe_bad == 0, "R7 enable only in reads", oe_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule